// File: doc/BRIEF.md
# System Management Interrupt Sequencer

This block turns a level-sensitive system management interrupt request into a clean exception entry for a simple in-order core. When the request is seen while interrupts are enabled, it stalls instruction dispatch at once. It then waits for every instruction still in flight to retire, and only then signals exception entry. The entry is a one-cycle strobe together with the handler vector address.

An older instruction that raises its own exception always goes first. The sequencer then drops back to idle and looks at the request line again afterwards. If the request line falls before entry, the request is abandoned and no vector is issued.

An enable bit masks recognition. It is cleared on entry so that the handler cannot be re-entered. The handler's return path sets it again through a set pulse.

Top module: `smi_sequencer`

## Requirements
- R1: After reset, `dispatch_stall_o`, `take_o` and `ee_o` are 0 and `vector_o` is all zeros.
- R2: In idle with `ee_o` = 1, a high `smi_req_i` raises `dispatch_stall_o` in that same cycle. With `ee_o` = 0 the request produces neither a stall nor an entry.
- R3: Outstanding work is `inflight_i` minus one when `retire_i` is high (a retirement in that cycle counts as complete). Entry is decided in the first drain cycle where the outstanding count is 0 and the request is still high. `take_o` rises in the following cycle, and the stall holds from detection through the `take_o` cycle.
- R4: If `smi_req_i` is low in any drain cycle, the request is abandoned: no `take_o` is produced, `dispatch_stall_o` falls in the next cycle, and `ee_o` stays 1.
- R5: `exc_pend_i` high in a drain cycle wins over entry, even when the core is drained in that cycle. The sequencer returns to idle for one cycle (the stall stays up while the request is still high and enabled) and then drains again from scratch.
- R6: `take_o` is high for exactly one cycle per entry. In that cycle `vector_o` equals `table_base_i` (sampled at the decision cycle) plus 0x01400. At all other times `vector_o` is 0.
- R7: `ee_o` is 0 from the `take_o` cycle onward. While it stays 0, holding or dropping `smi_req_i` has no effect on stall or entry.
- R8: A pulse on `ee_set_i` sets `ee_o` to 1 in the next cycle. A clear caused by entry in the same cycle takes priority over the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req_i | input | 1 | Level-sensitive system management interrupt request |
| ee_set_i | input | 1 | Pulse that sets the interrupt enable bit |
| inflight_i | input | CNT_W | Number of instructions in flight |
| retire_i | input | 1 | One instruction retires this cycle |
| exc_pend_i | input | 1 | An older in-flight instruction is raising its own exception |
| table_base_i | input | ADDR_W | Exception table base address |
| dispatch_stall_o | output | 1 | Blocks new instruction dispatch |
| take_o | output | 1 | One-cycle exception entry strobe |
| vector_o | output | ADDR_W | Handler address, valid while `take_o` is high |
| ee_o | output | 1 | Current interrupt enable bit |

## Verification
The bench sweeps the initial in-flight count and checks the exact entry cycle. A design that ignored the retirement pulse would enter one cycle late. One that skipped the drain wait would enter early.

It drops the request at every drain cycle before the decision. A design that latched the request would still vector even though the line had fallen. It raises an older exception at every drain cycle, including the cycle in which the core becomes empty. A design that let the interrupt win that race, or that did not restart the drain, would show entry at the wrong cycle.

After entry it holds the request high to catch a missing enable clear, which would appear as a second entry. It also checks the vector arithmetic across several table bases.

// File: rtl/smi_pkg.sv
package smi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_TAKE  = 2'd2
  } smi_state_e;

  localparam logic [19:0] SMI_VEC_OFS = 20'h01400;
endpackage

// File: rtl/smi_drain_detect.sv
module smi_drain_detect #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] inflight_i,
  input  logic             retire_i,
  output logic             drained_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_comb begin
    drained_o = (inflight_i == '0) || (retire_i && (inflight_i == ONE));
  end
endmodule

// File: rtl/smi_enable_reg.sv
module smi_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  logic en_q, en_d, en_we;

  always_comb begin
    en_we = set_i || clr_i;
    en_d  = !clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o = en_q;

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !en_o);
  assert_set_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> en_o);
endmodule

// File: rtl/smi_vector_gen.sv
module smi_vector_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] vec_o
);
  import smi_pkg::*;
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(SMI_VEC_OFS);

  logic [ADDR_W-1:0] vec_q, vec_d;
  logic              vec_we;

  always_comb begin
    vec_we = load_i || (vec_q != '0);
    vec_d  = load_i ? (base_i + OFS) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_we) vec_q <= vec_d;
  end

  assign vec_o = vec_q;

  assert_vector_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vec_o == $past(base_i) + OFS));
  assert_vector_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (vec_o == '0));
endmodule

// File: rtl/smi_seq_fsm.sv
module smi_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic en_i,
  input  logic exc_i,
  input  logic drained_i,
  output logic stall_o,
  output logic decide_o,
  output logic take_o
);
  import smi_pkg::*;

  smi_state_e state_q, state_d;
  logic       detect;

  always_comb begin
    detect   = req_i && en_i;
    decide_o = 1'b0;
    state_d  = state_q;
    unique case (state_q)
      ST_IDLE:  if (detect) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!req_i || exc_i) begin
          state_d = ST_IDLE;
        end else if (drained_i) begin
          state_d  = ST_TAKE;
          decide_o = 1'b1;
        end
      end
      ST_TAKE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    take_o  = (state_q == ST_TAKE);
    stall_o = (state_q != ST_IDLE) || detect;
  end

  assert_take_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(req_i));
  assert_older_exc_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(!exc_i && drained_i));
  assert_stall_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && en_i) |-> stall_o);
endmodule

// File: rtl/smi_sequencer.sv
module smi_sequencer #(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_req_i,
  input  logic              ee_set_i,
  input  logic [CNT_W-1:0]  inflight_i,
  input  logic              retire_i,
  input  logic              exc_pend_i,
  input  logic [ADDR_W-1:0] table_base_i,
  output logic              dispatch_stall_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              ee_o
);
  logic drained, decide;

  smi_drain_detect #(.CNT_W(CNT_W)) u_drain (
    .inflight_i (inflight_i),
    .retire_i   (retire_i),
    .drained_o  (drained)
  );

  smi_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (smi_req_i),
    .en_i      (ee_o),
    .exc_i     (exc_pend_i),
    .drained_i (drained),
    .stall_o   (dispatch_stall_o),
    .decide_o  (decide),
    .take_o    (take_o)
  );

  smi_enable_reg u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ee_set_i),
    .clr_i (decide),
    .en_o  (ee_o)
  );

  smi_vector_gen #(.ADDR_W(ADDR_W)) u_vec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (decide),
    .base_i (table_base_i),
    .vec_o  (vector_o)
  );

  assert_enable_off_in_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ee_o);
  assert_vector_only_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (vector_o == '0));
endmodule

// File: tb/test_smi_sequencer.sv
`timescale 1ns/1ps
module test_smi_sequencer;
  localparam int CNT_W  = 4;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smi_req_i, ee_set_i, retire_i, exc_pend_i;
  logic [CNT_W-1:0]  inflight_i;
  logic [ADDR_W-1:0] table_base_i;
  logic              dispatch_stall_o, take_o, ee_o;
  logic [ADDR_W-1:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  smi_sequencer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_smi_sequencer (
    .clk(clk), .rst_n(rst_n), .smi_req_i(smi_req_i), .ee_set_i(ee_set_i),
    .inflight_i(inflight_i), .retire_i(retire_i), .exc_pend_i(exc_pend_i),
    .table_base_i(table_base_i), .dispatch_stall_o(dispatch_stall_o),
    .take_o(take_o), .vector_o(vector_o), .ee_o(ee_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive just after the rising edge, observe 1 ns later
  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic enable_ints();
    ee_set_i = 1'b1;
    next_cycle();
    ee_set_i = 1'b0;
    #1;
    check(ee_o == 1'b1, "R8 enable set", ee_o, 1);
  endtask

  // n: initial in-flight count; drop: cycle request falls (0 = held);
  // exc: cycle of older exception pulse (0 = none)
  task automatic run_case(input int n, input int drop, input int exc, input logic [ADDR_W-1:0] base);
    int rem = n;
    int t_exp, first_take = -1, takes = 0;
    if (exc != 0) t_exp = ((exc + 2) > (n - 1) ? (exc + 2) : (n - 1)) + 1;
    else          t_exp = (n > 2) ? n : 2;
    table_base_i = base;
    for (int c = 0; c < 14; c++) begin
      smi_req_i  = (drop == 0) || (c < drop);
      exc_pend_i = (exc != 0) && (c == exc);
      inflight_i = CNT_W'(rem);
      retire_i   = (rem > 0);
      #1;
      if (drop != 0)
        check(dispatch_stall_o == (c <= drop), "R4 stall release after drop", dispatch_stall_o, c <= drop);
      else if (c == 0)
        check(dispatch_stall_o == 1'b1, "R2 stall on detection", dispatch_stall_o, 1);
      else
        check(dispatch_stall_o == (c <= t_exp), "R3 stall through drain", dispatch_stall_o, c <= t_exp);
      if (take_o) begin
        takes++;
        if (first_take < 0) first_take = c;
        check(vector_o == base + 32'h1400, "R6 vector value", vector_o, base + 32'h1400);
        check(ee_o == 1'b0, "R7 enable cleared on take", ee_o, 0);
      end else begin
        check(vector_o == '0, "R6 vector zero outside take", vector_o, 0);
      end
      next_cycle();
      if (rem > 0) rem--;
    end
    if (drop != 0) begin
      check(takes == 0, "R4 no take after early drop", takes, 0);
      check(ee_o == 1'b1, "R4 enable kept", ee_o, 1);
    end else begin
      check(takes == 1, "R6 single take strobe", takes, 1);
      if (exc != 0) check(first_take == t_exp, "R5 older exception first", first_take, t_exp);
      else          check(first_take == t_exp, "R3 take cycle after drain", first_take, t_exp);
    end
    smi_req_i = 1'b0; exc_pend_i = 1'b0; inflight_i = '0; retire_i = 1'b0;
    next_cycle();
  endtask

  initial begin
    rst_n = 1'b0; smi_req_i = 1'b0; ee_set_i = 1'b0; retire_i = 1'b0;
    exc_pend_i = 1'b0; inflight_i = '0; table_base_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check(dispatch_stall_o == 0 && take_o == 0 && ee_o == 0 && vector_o == 0,
          "R1 reset state", {dispatch_stall_o, take_o, ee_o}, 0);
    rst_n = 1'b1;
    next_cycle();

    // masked request: no stall, no entry (R2)
    smi_req_i = 1'b1;
    for (int c = 0; c < 6; c++) begin
      #1;
      check(dispatch_stall_o == 0 && take_o == 0, "R2 masked request ignored", dispatch_stall_o, 0);
      next_cycle();
    end
    smi_req_i = 1'b0;
    next_cycle();

    // drain sweep with varied bases (R3, R6)
    for (int n = 0; n <= 7; n++) begin
      enable_ints();
      run_case(n, 0, 0, 32'h0100_0000 * n + 32'h0000_2000);
    end

    // early drop at each drain cycle before the decision (R4)
    for (int d = 1; d <= 4; d++) begin
      enable_ints();
      run_case(6, d, 0, 32'hFFF0_0000);
    end

    // older exception at every drain cycle, including the drained one (R5)
    for (int n = 2; n <= 6; n++)
      for (int e = 1; e <= n - 1; e++) begin
        enable_ints();
        run_case(n, 0, e, 32'h8000_0000);
      end

    // after entry, request held with enable off has no effect (R7)
    enable_ints();
    run_case(0, 0, 0, 32'h0);
    smi_req_i = 1'b1;
    for (int c = 0; c < 5; c++) begin
      #1;
      check(dispatch_stall_o == 0 && take_o == 0, "R7 no re-entry while disabled", dispatch_stall_o, 0);
      next_cycle();
    end
    // set enable while request still high: stall returns at once (R8)
    ee_set_i = 1'b1;
    next_cycle();
    ee_set_i = 1'b0;
    #1;
    check(ee_o == 1 && dispatch_stall_o == 1, "R8 re-enable restores recognition", {ee_o, dispatch_stall_o}, 3);
    smi_req_i = 1'b0;
    repeat (4) next_cycle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 20000; w++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule